// File: doc/BRIEF.md
# Packed-Calendar Real-Time Clock Counter

This block keeps wall-clock time from a 32.768 kHz reference clock. A loadable prescaler counts reference cycles and emits one tick per second. Every tick advances a calendar of seconds, minutes, hours, day of month, month and year. The calendar follows month lengths and the Gregorian leap-year rule. A trim field lengthens or shortens one second out of every `TRIM_EVERY` seconds, which corrects a reference crystal that runs slightly fast or slow.

Software reaches the block through a small register bus with an address, a write strobe, write data and read data. There are three words. The prescaler configuration holds the divide value and the trim. The time-of-day word and the date word each pack their fields as plain binary numbers. Writing a time or date word loads the counters directly. Any write restarts the second in progress, so a value set by software is held for exactly one full second. The one-second tick also leaves the block as a single-cycle pulse.

Top module: `packed_rtc`

## Requirements
- R1: After reset the configuration word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x000FA021 (2000-01-01).
- R2: The configuration word is at offset 0x0C. Its bits [15:0] hold the divide value and bits [31:16] hold a two's-complement trim. The time word is at 0x10, with hours in [16:12], minutes in [11:6] and seconds in [5:0]. The date word is at 0x14, with the full year in [20:9], the month (1-12) in [8:5] and the day (from 1) in [4:0]. A write stores the value as given and reads back unchanged. Any other offset reads 0.
- R3: While the divide value is 0, no tick is produced and the calendar holds its value.
- R4: With a nonzero divide value D and no trim in effect, ticks come every D+1 clock cycles. `tick_1hz` is high for one cycle per tick. While it is high, the calendar already shows the advanced value.
- R5: Every `TRIM_EVERY`-th second after a restart lasts D+1+T cycles, where T is the signed trim. The count is restarted at each write. If D+1+T is below 1, that second lasts 1 cycle.
- R6: A write to any of the three words restarts the prescaler and the trim sequence. The first tick comes D+1 cycles after the write edge.
- R7: On a tick, seconds step by one. At 59 they roll to 0 and carry into minutes. Minutes roll at 59 and carry into hours. Hours roll at 23 and carry into the day.
- R8: The day rolls to 1 and the month advances after day 30 in April, June, September and November, and after day 31 in the other 31-day months.
- R9: February ends at day 29 when the year is divisible by 4 and not by 100, or is divisible by 400. Otherwise it ends at day 28.
- R10: After December 31 the date becomes January 1 of the next year.
- R11: A field that is written at or above its largest legal value is treated as that largest value. On the next advance it rolls to its minimum and carries. For example, seconds written as 62 become 0 and the minutes advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_1hz | output | 1 | One-cycle pulse per elapsed second |

## Verification
The bench drives the whole-chain carry 23:59:59 into a new year, and the three February outcomes: century years 1900 and 2000 and ordinary year 2024. A design that tested only divisibility by 4 would produce February 29 in 1900. A design that left out the 400 rule would skip February 29, 2000. It times the distance between ticks with and without trim, including a negative trim large enough to need clamping. A lost restart on write, or a trim applied to the wrong second, shows up as a wrong interval count. A seconds value written out of range must carry on the next advance. A design that used equality to detect the roll would let it run on past 59 instead.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int OFS_CFG  = 'h0C;
    localparam int OFS_TIME = 'h10;
    localparam int OFS_DATE = 'h14;
    localparam int WORD_W   = 32;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  month;
        logic [4:0]  day;
    } date_t;

    localparam int TOD_W  = $bits(tod_t);
    localparam int DATE_W = $bits(date_t);

    localparam tod_t  TOD_RESET  = '{hour: 5'd0, min: 6'd0, sec: 6'd0};
    localparam date_t DATE_RESET = '{year: 12'd2000, month: 4'd1, day: 5'd1};

    function automatic logic is_leap(input logic [11:0] y);
        return ((y[1:0] == 2'b00) && ((y % 12'd100) != 12'd0)) ||
               ((y % 12'd400) == 12'd0);
    endfunction

    function automatic logic [4:0] month_len(input logic [11:0] y, input logic [3:0] m);
        case (m)
            4'd2:                      return is_leap(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W      = 16,
    parameter int TRIM_W     = 16,
    parameter int TRIM_EVERY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [TRIM_W-1:0] trim_val,
    output logic              wrap,
    output logic              tick_o
);
    localparam int CNT_W = ((DIV_W > TRIM_W) ? DIV_W : TRIM_W) + 1;
    localparam int SUM_W = CNT_W + 1;
    localparam int IDX_W = (TRIM_EVERY > 1) ? $clog2(TRIM_EVERY) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TRIM_EVERY - 1);

    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] idx_q;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] lim;
    logic             enabled;
    logic             use_trim;

    assign enabled  = (div_val != '0);
    assign use_trim = (idx_q == IDX_LAST);

    always_comb begin
        sum = {{(SUM_W-DIV_W){1'b0}}, div_val};
        if (use_trim)
            sum = sum + {{(SUM_W-TRIM_W){trim_val[TRIM_W-1]}}, trim_val};
        lim = sum[SUM_W-1] ? '0 : sum[CNT_W-1:0];
    end

    assign wrap = enabled && !restart && (count_q == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            idx_q   <= '0;
            tick_o  <= 1'b0;
        end else begin
            tick_o <= wrap;
            if (restart || !enabled) begin
                count_q <= '0;
                idx_q   <= '0;
            end else if (wrap) begin
                count_q <= '0;
                idx_q   <= use_trim ? '0 : idx_q + 1'b1;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= lim);

    // R3
    no_tick_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!enabled) |=> !tick_o);

    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count_q == '0 && idx_q == '0));

endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  tod_t load_val,
    output tod_t tod_q,
    output logic day_carry
);
    tod_t nxt;
    logic sec_end, min_end, hour_end;

    assign sec_end  = (tod_q.sec  >= 6'd59);
    assign min_end  = (tod_q.min  >= 6'd59);
    assign hour_end = (tod_q.hour >= 5'd23);

    assign day_carry = adv && !load && sec_end && min_end && hour_end;

    always_comb begin
        nxt = tod_q;
        if (sec_end) begin
            nxt.sec = '0;
            if (min_end) begin
                nxt.min = '0;
                nxt.hour = hour_end ? '0 : tod_q.hour + 1'b1;
            end else begin
                nxt.min = tod_q.min + 1'b1;
            end
        end else begin
            nxt.sec = tod_q.sec + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tod_q <= TOD_RESET;
        else if (load)
            tod_q <= load_val;
        else if (adv)
            tod_q <= nxt;
    end

    // R7
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && tod_q.sec == 6'd59) |=> (tod_q.sec == 6'd0));

    // R7
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && tod_q.sec < 6'd59) |=> (tod_q.sec == $past(tod_q.sec) + 6'd1));

    // R3
    tod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(tod_q));

endmodule

// File: rtl/rtc_date.sv
module rtc_date
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  load,
    input  date_t load_val,
    output date_t date_q
);
    date_t      nxt;
    logic [4:0] last_day;

    assign last_day = month_len(date_q.year, date_q.month);

    always_comb begin
        nxt = date_q;
        if (date_q.day >= last_day) begin
            nxt.day = 5'd1;
            if (date_q.month >= 4'd12) begin
                nxt.month = 4'd1;
                nxt.year  = date_q.year + 1'b1;
            end else begin
                nxt.month = date_q.month + 1'b1;
            end
        end else begin
            nxt.day = date_q.day + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            date_q <= DATE_RESET;
        else if (load)
            date_q <= load_val;
        else if (adv)
            date_q <= nxt;
    end

    // R8
    day_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && date_q.day >= last_day) |=> (date_q.day == 5'd1));

    // R10
    year_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && date_q.month >= 4'd12 && date_q.day >= last_day)
        |=> (date_q.year == $past(date_q.year) + 12'd1 && date_q.month == 4'd1));

endmodule

// File: rtl/packed_rtc.sv
module packed_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DIV_W      = 16,
    parameter int TRIM_W     = 16,
    parameter int TRIM_EVERY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tick_1hz
);
    localparam int CFG_W = DIV_W + TRIM_W;

    logic [CFG_W-1:0] cfg_q;
    logic sel_cfg, sel_time, sel_date;
    logic wr_cfg, wr_time, wr_date, any_wr;
    logic sec_wrap, day_carry;
    tod_t  tod_q;
    date_t date_q;

    assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign sel_time = (bus_addr == ADDR_W'(OFS_TIME));
    assign sel_date = (bus_addr == ADDR_W'(OFS_DATE));
    assign wr_cfg   = bus_wr && sel_cfg;
    assign wr_time  = bus_wr && sel_time;
    assign wr_date  = bus_wr && sel_date;
    assign any_wr   = wr_cfg || wr_time || wr_date;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_cfg)
            cfg_q <= bus_wdata[CFG_W-1:0];
    end

    rtc_prescaler #(
        .DIV_W(DIV_W), .TRIM_W(TRIM_W), .TRIM_EVERY(TRIM_EVERY)
    ) u_presc (
        .clk      (clk),
        .rst      (rst),
        .restart  (any_wr),
        .div_val  (cfg_q[DIV_W-1:0]),
        .trim_val (cfg_q[CFG_W-1:DIV_W]),
        .wrap     (sec_wrap),
        .tick_o   (tick_1hz)
    );

    rtc_tod u_tod (
        .clk       (clk),
        .rst       (rst),
        .adv       (sec_wrap),
        .load      (wr_time),
        .load_val  (tod_t'(bus_wdata[TOD_W-1:0])),
        .tod_q     (tod_q),
        .day_carry (day_carry)
    );

    rtc_date u_date (
        .clk      (clk),
        .rst      (rst),
        .adv      (day_carry),
        .load     (wr_date),
        .load_val (date_t'(bus_wdata[DATE_W-1:0])),
        .date_q   (date_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg)
            bus_rdata = {{(WORD_W-CFG_W){1'b0}}, cfg_q};
        else if (sel_time)
            bus_rdata = {{(WORD_W-TOD_W){1'b0}}, tod_q};
        else if (sel_date)
            bus_rdata = {{(WORD_W-DATE_W){1'b0}}, date_q};
    end

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && cfg_q[DIV_W-1:0] != '0 && $past(cfg_q[DIV_W-1:0]) != '0
         && cfg_q[CFG_W-1:DIV_W] == '0) |=> !tick_1hz);

    // R2
    time_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_time |=> (tod_q == tod_t'($past(bus_wdata[TOD_W-1:0]))));

endmodule

// File: tb/test_packed_rtc.sv
module test_packed_rtc;

    localparam int A_CFG  = 'h0C;
    localparam int A_TIME = 'h10;
    localparam int A_DATE = 'h14;

    typedef struct {
        int          addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1hz;

    int checks = 0;
    int errors = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    packed_rtc i_packed_rtc (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1hz(tick_1hz)
    );

    function automatic logic [31:0] pk_date(int y, int m, int d);
        return (32'(y) << 9) | (32'(m) << 5) | 32'(d);
    endfunction

    function automatic logic [31:0] pk_time(int h, int mi, int s);
        return (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
    endfunction

    task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected reads and compares
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            bus_addr = 8'(exp_q[0].addr);
            #1;
            check_val(exp_q[0].req, bus_rdata, exp_q[0].exp);
            void'(exp_q.pop_front());
        end
    end

    task automatic expect_read(int addr, logic [31:0] exp, string req);
        item_t it;
        it.addr = addr; it.exp = exp; it.req = req;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic bus_write(int addr, logic [31:0] data);
        bus_addr  = 8'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_1hz && n < 1000);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic roll_case(logic [31:0] d_in, logic [31:0] t_in,
                             logic [31:0] d_exp, logic [31:0] t_exp, string req);
        int n;
        bus_write(A_CFG, 32'd0);
        bus_write(A_DATE, d_in);
        bus_write(A_TIME, t_in);
        bus_write(A_CFG, 32'd1);
        wait_tick(n);
        bus_write(A_CFG, 32'd0);
        expect_read(A_TIME, t_exp, req);
        expect_read(A_DATE, d_exp, req);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int n;
        int ticks;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_read(A_CFG, 32'h0, "R1");
        expect_read(A_TIME, 32'h0, "R1");
        expect_read(A_DATE, 32'h000FA021, "R1");
        // R2 unmapped offset
        expect_read('h00, 32'h0, "R2");

        // R3 divide zero: no ticks, calendar holds
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick_1hz) ticks++;
        end
        check_val("R3", 32'(ticks), 32'd0);
        expect_read(A_TIME, 32'h0, "R3");

        // R4 period D+1 and calendar already advanced on tick
        bus_write(A_CFG, 32'd4);
        wait_tick(n);
        check_val("R4", 32'(n), 32'd5);
        expect_read(A_TIME, pk_time(0, 0, 1), "R4");
        wait_tick(n);
        check_val("R4", 32'(n), 32'd5);
        @(negedge clk);
        check_val("R4", {31'd0, tick_1hz}, 32'd0);

        // R2 configuration readback
        bus_write(A_CFG, 32'h0003_0004);
        expect_read(A_CFG, 32'h0003_0004, "R2");

        // R5 positive trim on every fourth second: 5,5,5,8,5
        bus_write(A_CFG, 32'h0003_0004);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);
        wait_tick(n); check_val("R5", 32'(n), 32'd8);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);

        // R5 negative trim clamped to one cycle
        bus_write(A_CFG, 32'hFFFA_0004);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);
        wait_tick(n); check_val("R5", 32'(n), 32'd5);
        wait_tick(n); check_val("R5", 32'(n), 32'd1);

        // R6 write restarts the second
        bus_write(A_CFG, 32'd9);
        repeat (6) @(negedge clk);
        bus_write(A_TIME, pk_time(3, 4, 5));
        wait_tick(n);
        check_val("R6", 32'(n), 32'd10);
        bus_write(A_CFG, 32'd0);
        expect_read(A_TIME, pk_time(3, 4, 6), "R6");

        // R2 date write loads directly
        bus_write(A_DATE, pk_date(2031, 7, 19));
        expect_read(A_DATE, pk_date(2031, 7, 19), "R2");

        // R7 plain step and full carry chain
        roll_case(pk_date(2024, 5, 10), pk_time(10, 15, 30),
                  pk_date(2024, 5, 10), pk_time(10, 15, 31), "R7");
        roll_case(pk_date(2024, 5, 10), pk_time(10, 59, 59),
                  pk_date(2024, 5, 10), pk_time(11, 0, 0), "R7");
        roll_case(pk_date(2024, 5, 10), pk_time(23, 59, 59),
                  pk_date(2024, 5, 11), pk_time(0, 0, 0), "R7");
        // R8 month lengths
        roll_case(pk_date(2024, 4, 30), pk_time(23, 59, 59),
                  pk_date(2024, 5, 1), pk_time(0, 0, 0), "R8");
        roll_case(pk_date(2024, 8, 30), pk_time(23, 59, 59),
                  pk_date(2024, 8, 31), pk_time(0, 0, 0), "R8");
        // R9 leap rules
        roll_case(pk_date(2023, 2, 28), pk_time(23, 59, 59),
                  pk_date(2023, 3, 1), pk_time(0, 0, 0), "R9");
        roll_case(pk_date(2024, 2, 28), pk_time(23, 59, 59),
                  pk_date(2024, 2, 29), pk_time(0, 0, 0), "R9");
        roll_case(pk_date(2024, 2, 29), pk_time(23, 59, 59),
                  pk_date(2024, 3, 1), pk_time(0, 0, 0), "R9");
        roll_case(pk_date(1900, 2, 28), pk_time(23, 59, 59),
                  pk_date(1900, 3, 1), pk_time(0, 0, 0), "R9");
        roll_case(pk_date(2000, 2, 28), pk_time(23, 59, 59),
                  pk_date(2000, 2, 29), pk_time(0, 0, 0), "R9");
        // R10 year end
        roll_case(pk_date(2099, 12, 31), pk_time(23, 59, 59),
                  pk_date(2100, 1, 1), pk_time(0, 0, 0), "R10");
        // R11 out-of-range seconds
        roll_case(pk_date(2024, 5, 10), pk_time(8, 20, 62),
                  pk_date(2024, 5, 10), pk_time(8, 21, 0), "R11");

        finish_run();
    end

endmodule